// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Generator

This block raises the receive and transmit interrupt requests of a UART from the fill state of its two FIFOs. Each cycle it is given the occupancy of the receive FIFO and of the transmit FIFO. It compares a level taken from each count against a threshold that software selects. When that level moves from below the threshold to at or above it, the block sets a sticky flag, and the flag drives the interrupt line.

Both thresholds live in one configuration register, with a 3-bit code for each direction. The codes map to 1/8, 1/4, 1/2, 3/4 and 7/8 of the FIFO depth. With the default depth of 16, that gives 2, 4, 8, 12 and 14 entries. The receive side measures how many entries are stored in the FIFO; each entry is 12 bits, made of 8 data bits and 4 status bits. The transmit side measures how many free slots remain in the FIFO; each entry is 8 bits. A flag is set only when the level crosses the threshold, never because the level already sits past it. Software clears a flag by writing a one to its bit at a second address.

Top module: `uart_lvl_irq`

## Requirements
- R1: After reset, both threshold codes are 3'b010, both interrupt outputs are low, and a read of the configuration address returns 32'h0000_0012.
- R2: A write to address 0 stores wdata[5:0]: the receive code goes in bits [5:3] and the transmit code in bits [2:0]. The read data is registered: it shows the addressed value one cycle after the address is presented, and it shows the value held before any write in that same cycle. Bits [31:6] of a configuration read and every bit of a read from any other address return zero.
- R3: Receive codes 000, 001, 010, 011 and 100 select thresholds of 2, 4, 8, 12 and 14 stored entries. rx_irq rises when rx_count goes from below the threshold to at or above it.
- R4: The transmit level is 16 − tx_count. Transmit codes 000 through 100 select thresholds of 2, 4, 8, 12 and 14 free entries. tx_irq rises when the free count goes from below the threshold to at or above it.
- R5: A count that stays at or above the threshold does not set a flag. This holds after a clear, and it holds when the threshold is lowered beneath the present level.
- R6: Reserved codes 101, 110 and 111 behave as code 010 (threshold 8). They still read back as the code that was written.
- R7: A flag stays high until software writes to address 1 with bit 0 set (clears rx) or bit 1 set (clears tx). A zero bit leaves its flag unchanged.
- R8: When a crossing and a clear of the same flag happen in the same cycle, the flag stays set.
- R9: A count change that jumps over the threshold by several entries in one cycle counts as a crossing.
- R10: A flag is high at the output right after the clock edge that samples the crossing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address: 0 selects the configuration register, 1 selects the flag clear |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rx_count | input | CNT_W | Number of entries stored in the receive FIFO (0..DEPTH) |
| tx_count | input | CNT_W | Number of entries stored in the transmit FIFO (0..DEPTH) |
| rx_irq | output | 1 | Sticky receive interrupt |
| tx_irq | output | 1 | Sticky transmit interrupt |

## Verification
The bench targets these corner cases:
- A level that is already past the threshold, which a level-triggered design would flag again right after a clear.
- A threshold lowered beneath the present count, which a design comparing only the current count would flag.
- Multi-entry jumps across the threshold, which an equality test would miss.
- A clear that arrives in the same cycle as a crossing, which a clear-priority flag would lose.
- Reserved codes, which a decoder without a default would map to a zero or undefined threshold.

The transmit side is driven by draining, so that a design comparing occupancy instead of free space fires at the wrong end.

// File: rtl/uart_lvl_pkg.sv
package uart_lvl_pkg;

  typedef enum logic [2:0] {
    LVL_EIGHTH  = 3'd0,
    LVL_QUARTER = 3'd1,
    LVL_HALF    = 3'd2,
    LVL_3QUART  = 3'd3,
    LVL_7EIGHTH = 3'd4
  } lvl_code_e;

  localparam logic [2:0] LVL_RESET_CODE = LVL_HALF;

  // Threshold in entries for a code and a FIFO depth; reserved codes map to half.
  function automatic int unsigned lvl_of(input logic [2:0] code, input int unsigned depth);
    case (code)
      LVL_EIGHTH:  return depth / 8;
      LVL_QUARTER: return depth / 4;
      LVL_3QUART:  return (3 * depth) / 4;
      LVL_7EIGHTH: return (7 * depth) / 8;
      default:     return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_lvl_regs.sv
module uart_lvl_regs
  import uart_lvl_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CFG_ADDR = 0,
  parameter int CLR_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [2:0]        rx_code,
  output logic [2:0]        tx_code,
  output logic              rx_clr,
  output logic              tx_clr
);

  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

  logic cfg_hit;
  logic clr_hit;
  logic unused_wdata_hi;

  assign cfg_hit = reg_addr == CFG_A;
  assign clr_hit = reg_addr == CLR_A;
  assign unused_wdata_hi = ^reg_wdata[31:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_code <= LVL_RESET_CODE;
      tx_code <= LVL_RESET_CODE;
    end else if (reg_wr && cfg_hit) begin
      rx_code <= reg_wdata[5:3];
      tx_code <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (cfg_hit) begin
      reg_rdata <= {26'd0, rx_code, tx_code};
    end else begin
      reg_rdata <= '0;
    end
  end

  assign rx_clr = reg_wr && clr_hit && reg_wdata[0];
  assign tx_clr = reg_wr && clr_hit && reg_wdata[1];

endmodule

// File: rtl/uart_lvl_decode.sv
module uart_lvl_decode
  import uart_lvl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] thr
);

  always_comb begin
    thr = CNT_W'(lvl_of(code, DEPTH));
  end

endmodule

// File: rtl/uart_lvl_cross.sv
module uart_lvl_cross #(
  parameter int CNT_W     = 5,
  parameter int RESET_LVL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thr,
  input  logic             clr,
  output logic             flag
);

  logic [CNT_W-1:0] prev_lvl;
  logic             crossing;

  assign crossing = (prev_lvl < thr) && (level >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= CNT_W'(RESET_LVL);
      flag     <= 1'b0;
    end else begin
      prev_lvl <= level;
      if (crossing) begin
        flag <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_lvl_irq.sv
module uart_lvl_irq
  import uart_lvl_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 2,
  parameter int CFG_ADDR = 0,
  parameter int CLR_ADDR = 1,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  output logic              rx_irq,
  output logic              tx_irq
);

  localparam int NCH = 2;

  logic [2:0]       chan_code [NCH];
  logic [CNT_W-1:0] chan_lvl  [NCH];
  logic [CNT_W-1:0] chan_thr  [NCH];
  logic             chan_clr  [NCH];
  logic             chan_flag [NCH];

  logic [2:0] rx_code_w;
  logic [2:0] tx_code_w;
  logic       rx_clr_w;
  logic       tx_clr_w;

  uart_lvl_regs #(
    .ADDR_W  (ADDR_W),
    .CFG_ADDR(CFG_ADDR),
    .CLR_ADDR(CLR_ADDR)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rx_code  (rx_code_w),
    .tx_code  (tx_code_w),
    .rx_clr   (rx_clr_w),
    .tx_clr   (tx_clr_w)
  );

  assign chan_code[0] = rx_code_w;
  assign chan_code[1] = tx_code_w;
  assign chan_clr[0]  = rx_clr_w;
  assign chan_clr[1]  = tx_clr_w;
  // Receive level is occupancy; transmit level is free space.
  assign chan_lvl[0]  = rx_count;
  assign chan_lvl[1]  = CNT_W'(DEPTH) - tx_count;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    uart_lvl_decode #(
      .DEPTH(DEPTH),
      .CNT_W(CNT_W)
    ) i_decode (
      .code(chan_code[g]),
      .thr (chan_thr[g])
    );

    uart_lvl_cross #(
      .CNT_W    (CNT_W),
      .RESET_LVL((g == 0) ? 0 : DEPTH)
    ) i_cross (
      .clk  (clk),
      .rst  (rst),
      .level(chan_lvl[g]),
      .thr  (chan_thr[g]),
      .clr  (chan_clr[g]),
      .flag (chan_flag[g])
    );
  end

  assign rx_irq = chan_flag[0];
  assign tx_irq = chan_flag[1];

endmodule

// File: rtl/uart_lvl_irq_chk.sv
module uart_lvl_irq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_thr,
  input logic [CNT_W-1:0] tx_thr,
  input logic             rx_clr,
  input logic             tx_clr,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic [25:0]      rdata_hi
);

  logic             armed;
  logic [CNT_W-1:0] tx_free;

  assign tx_free = CNT_W'(DEPTH) - tx_count;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (armed && $past(rst)) |-> (!rx_irq && !tx_irq));

  // R2
  rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_hi == '0);

  // R7
  rx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !rx_clr) |=> rx_irq);

  // R7
  tx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !tx_clr) |=> tx_irq);

  // R3
  rx_rise_cross_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> (($past(rx_count) >= $past(rx_thr)) &&
                       ($past(rx_count, 2) < $past(rx_thr))));

  // R4
  tx_rise_cross_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_irq) |-> (($past(tx_free) >= $past(tx_thr)) &&
                       ($past(tx_free, 2) < $past(tx_thr))));

endmodule

bind uart_lvl_irq uart_lvl_irq_chk #(
  .DEPTH(DEPTH),
  .CNT_W(CNT_W)
) i_uart_lvl_irq_chk (
  .clk     (clk),
  .rst     (rst),
  .rx_count(rx_count),
  .tx_count(tx_count),
  .rx_thr  (chan_thr[0]),
  .tx_thr  (chan_thr[1]),
  .rx_clr  (rx_clr_w),
  .tx_clr  (tx_clr_w),
  .rx_irq  (rx_irq),
  .tx_irq  (tx_irq),
  .rdata_hi(reg_rdata[31:6])
);

// File: tb/test_uart_lvl_irq.sv
module test_uart_lvl_irq;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int ADDR_W     = 2;
  localparam int CNT_W      = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [CNT_W-1:0]  rx_count = '0;
  logic [CNT_W-1:0]  tx_count = '0;
  logic              rx_irq;
  logic              tx_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int cur_rx = 0;
  int cur_tx = 0;

  // bench model state
  logic [5:0]  m_cfg = 6'b010010;
  int          m_prx = 0;
  int          m_ptx = DEPTH;
  logic        m_rx = 0;
  logic        m_tx = 0;
  logic [31:0] m_rd = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_lvl_irq #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) i_uart_lvl_irq (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq)
  );

  function automatic int thr_of(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 4;
      3'd3: return 12;
      3'd4: return 14;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // One clock cycle with the given register access; model updated and outputs compared.
  task automatic cyc(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int trx, ttx, fr;
    logic crx, ctx;
    @(negedge clk);
    rx_count  = CNT_W'(cur_rx);
    tx_count  = CNT_W'(cur_tx);
    reg_wr    = w;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    trx = thr_of(m_cfg[5:3]);
    ttx = thr_of(m_cfg[2:0]);
    fr  = DEPTH - cur_tx;
    crx = (m_prx < trx) && (cur_rx >= trx);
    ctx = (m_ptx < ttx) && (fr >= ttx);
    m_rd = (a == 0) ? {26'd0, m_cfg} : 32'd0;
    m_rx = crx ? 1'b1 : ((w && a == 1 && d[0]) ? 1'b0 : m_rx);
    m_tx = ctx ? 1'b1 : ((w && a == 1 && d[1]) ? 1'b0 : m_tx);
    m_prx = cur_rx;
    m_ptx = fr;
    if (w && a == 0) m_cfg = d[5:0];
    #(CLK_PERIOD / 4);
    chk("R3 rx_irq", {31'd0, rx_irq}, {31'd0, m_rx});
    chk("R4 tx_irq", {31'd0, tx_irq}, {31'd0, m_tx});
    chk("R2 rdata", reg_rdata, m_rd);
  endtask

  task automatic idle();
    cyc(1'b0, 2'd0, 32'd0);
  endtask

  task automatic wcfg(input logic [2:0] rc, input logic [2:0] tc);
    cyc(1'b1, 2'd0, {26'd0, rc, tc});
  endtask

  task automatic wclr(input logic [1:0] bits);
    cyc(1'b1, 2'd1, {30'd0, bits});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD / 4);
    // R1: quiet after reset
    chk("R1 rx_irq", {31'd0, rx_irq}, 32'd0);
    chk("R1 tx_irq", {31'd0, tx_irq}, 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    idle();
    chk("R1 cfg reset", reg_rdata, 32'h12);

    // R3 and R10: each receive code, flag right after the crossing edge
    cur_tx = DEPTH;
    for (int c = 0; c < 5; c++) begin
      int t;
      t = thr_of(3'(c));
      cur_rx = 0; idle();
      wcfg(3'(c), 3'd2);
      wclr(2'b11);
      cur_rx = t - 1; idle();
      chk("R3 below", {31'd0, rx_irq}, 32'd0);
      cur_rx = t; idle();
      chk("R10 rx set", {31'd0, rx_irq}, 32'd1);
    end

    // R4: each transmit code, draining the FIFO
    cur_rx = 0;
    for (int c = 0; c < 5; c++) begin
      int t;
      t = thr_of(3'(c));
      cur_tx = DEPTH; idle();
      wcfg(3'd2, 3'(c));
      wclr(2'b11);
      cur_tx = DEPTH - t + 1; idle();
      chk("R4 below", {31'd0, tx_irq}, 32'd0);
      cur_tx = DEPTH - t; idle();
      chk("R4 tx set", {31'd0, tx_irq}, 32'd1);
    end

    // R5: level held above threshold, cleared, and threshold lowered
    cur_tx = DEPTH; idle();
    wcfg(3'd4, 3'd2);
    cur_rx = 15; idle();
    wclr(2'b11);
    repeat (3) idle();
    chk("R5 held above", {31'd0, rx_irq}, 32'd0);
    wcfg(3'd0, 3'd2);
    repeat (2) idle();
    chk("R5 lowered thr", {31'd0, rx_irq}, 32'd0);

    // R6: reserved code acts as threshold 8 and reads back
    cur_rx = 0; idle();
    wcfg(3'd7, 3'd5);
    idle();
    chk("R6 readback", reg_rdata, 32'h3D);
    cur_rx = 7; idle();
    chk("R6 below 8", {31'd0, rx_irq}, 32'd0);
    cur_rx = 8; idle();
    chk("R6 at 8", {31'd0, rx_irq}, 32'd1);

    // R7: zero bit leaves flags, one bit clears only its flag
    cur_tx = 8; idle();
    chk("R7 tx set", {31'd0, tx_irq}, 32'd1);
    wclr(2'b00);
    chk("R7 rx kept", {31'd0, rx_irq}, 32'd1);
    wclr(2'b01);
    chk("R7 rx cleared", {31'd0, rx_irq}, 32'd0);
    chk("R7 tx kept", {31'd0, tx_irq}, 32'd1);

    // R8: clear in the crossing cycle loses to the set
    cur_rx = 7; idle();
    cur_rx = 8;
    wclr(2'b01);
    chk("R8 set wins", {31'd0, rx_irq}, 32'd1);

    // R9: multi-entry jump
    cur_rx = 0; idle();
    wcfg(3'd1, 3'd2);
    wclr(2'b11);
    cur_rx = 16; idle();
    chk("R9 jump", {31'd0, rx_irq}, 32'd1);

    // random phase, checked against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      cur_rx = cur_rx + int'($urandom_range(6)) - 3;
      cur_tx = cur_tx + int'($urandom_range(6)) - 3;
      if (cur_rx < 0) cur_rx = 0;
      if (cur_rx > DEPTH) cur_rx = DEPTH;
      if (cur_tx < 0) cur_tx = 0;
      if (cur_tx > DEPTH) cur_tx = DEPTH;
      r = int'($urandom_range(99));
      if (r < 8) wcfg(3'($urandom_range(7)), 3'($urandom_range(7)));
      else if (r < 18) wclr(2'($urandom_range(3)));
      else if (r < 22) cyc(1'b1, 2'($urandom_range(2, 3)), $urandom);
      else cyc(1'b0, 2'($urandom_range(3)), 32'd0);
    end

    finish_run();
  end

endmodule